// File: doc/BRIEF.md
# Recursive Twiddle Factor Generator

This block feeds an FFT butterfly engine with the complex twiddle factor it needs at each point of a radix-2 pass, and it does so without a sine/cosine table. It holds two rotations, both in signed fixed point. The first is a per-stage base rotation. The second is a running twiddle that the engine reads out as a real/imaginary pair.

Each advance request turns the running twiddle once by the base rotation, using a complex multiply with rounding. At the end of a stage, the base rotation is replaced by the half-angle rotation. Its cosine part is sqrt((1+c)/2) and its sine part has magnitude sqrt((1-c)/2), where c is the current cosine. The sine part is negative for a forward transform and positive for an inverse one.

The two square roots come from two bit-serial restoring units that run side by side. While they run, the valid flag is low. An advance requested during that time is held and then applied with the new base rotation. A row-start command returns both rotations to their starting values. Because the base angle halves at each stage end, a stage started after k stage ends steps the twiddle through multiples of pi/2^k.

Top module: `twg_gen`

## Requirements
- R1: After reset the twiddle output is (+1.0, 0) = (2^FRAC, 0), valid_o is high, and the base rotation is (-1.0, 0). As a result, a first advance yields (-2^FRAC, 0).
- R2: A row-start pulse sets the twiddle to (2^FRAC, 0) and the base rotation to (-2^FRAC, 0), with valid_o high, all on the next cycle. It also cancels any base update in progress, so that update never lands.
- R3: A stage-init pulse sets the twiddle to (2^FRAC, 0) on the next cycle and leaves the base rotation unchanged. Row-start takes priority over it when both arrive in the same cycle.
- R4: With no update in progress, an advance pulse replaces (u1, u2) on the next cycle. The new u1 is round(u1*c - u2*s) and the new u2 is round(u1*s + u2*c), both computed from the old values and scaled by 2^-FRAC. valid_o stays high.
- R5: A stage-end pulse drops valid_o on the next cycle and raises it again exactly FRAC+2 cycles after the edge that sampled the pulse. At that point the new cosine is floor(sqrt((1+c)/2)) in Q format and is non-negative.
- R6: The inverse_i level sampled together with stage-end sets the sign of the new sine part: 0 gives a sine part that is zero or negative (forward), and 1 gives one that is zero or positive (inverse).
- R7: An advance requested while an update is in progress leaves the twiddle unchanged and valid_o low until the update completes. It is then applied with the new base rotation, and only after that does valid_o rise.
- R8: After j advances in a stage that follows k stage ends, the twiddle is within 6+6j LSB of (cos(j*t), sin(j*t)) * 2^FRAC, where t = -pi/2^k for a forward transform and +pi/2^k for an inverse one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| row_init_i | input | 1 | Row-start pulse: reset the base rotation and the twiddle |
| stage_init_i | input | 1 | Stage-init pulse: reset the twiddle to (1, 0) |
| stage_end_i | input | 1 | Stage-end pulse: start the half-angle base update |
| advance_i | input | 1 | Rotate the twiddle by the base rotation |
| inverse_i | input | 1 | 0 for a forward transform, 1 for an inverse transform |
| u1_o | output | W | Twiddle real part, signed, FRAC fraction bits |
| u2_o | output | W | Twiddle imaginary part, signed, FRAC fraction bits |
| valid_o | output | 1 | Twiddle reflects every accepted request |

## Verification
The bench builds the block with its defaults, W=16 and FRAC=14, so 1.0 is 16384. It drives up to four stage ends in both directions, which brings base angles from pi down to pi/16 and up to 16 advances within one stage. These settings make the first two stages bit-exact (±16384 and 0), because the square roots of 0 and 2^28 have no rounding error. The later stages are checked against cosines and sines computed in the bench, with a tolerance that grows with the number of advances. The 15-bit square-root latency fixes the exact FRAC+2 cycle window in which advances are stalled and row-start aborts are tested.

// File: rtl/twg_pkg.sv
package twg_pkg;
  // Action applied to the running twiddle in one cycle.
  typedef enum logic [1:0] {
    UOP_HOLD = 2'd0,
    UOP_ROW  = 2'd1,
    UOP_UNIT = 2'd2,
    UOP_TURN = 2'd3
  } twg_uop_e;
endpackage

// File: rtl/twg_sqrt.sv
// Bit-serial restoring square root: N result bits from a 2N-bit radicand,
// one result bit per cycle, result floored.
module twg_sqrt #(
  parameter int N = 15
) (
  input  logic           clk_i,
  input  logic           rst_i,
  input  logic           start_i,
  input  logic [2*N-1:0] rad_i,
  output logic           done_o,
  output logic [N-1:0]   root_o
);
  localparam int CW  = $clog2(N + 1);
  localparam int RMW = N + 3;

  logic [2*N-1:0] rad_q;
  logic [RMW-1:0] rem_q, rem_sh, trial, rem_nx;
  logic [N-1:0]   root_q, root_nx;
  logic [CW-1:0]  cnt_q;
  logic           done_q, ge;

  always_comb begin
    rem_sh  = (rem_q << 2) | RMW'(rad_q[2*N-1 -: 2]);
    trial   = RMW'({root_q, 2'b01});
    ge      = (rem_sh >= trial);
    rem_nx  = ge ? (rem_sh - trial) : rem_sh;
    root_nx = {root_q[N-2:0], ge};
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rad_q  <= '0;
      rem_q  <= '0;
      root_q <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (start_i) begin
      rad_q  <= rad_i;
      rem_q  <= '0;
      root_q <= '0;
      cnt_q  <= CW'(N);
      done_q <= 1'b0;
    end else if (cnt_q != '0) begin
      rad_q  <= rad_q << 2;
      rem_q  <= rem_nx;
      root_q <= root_nx;
      cnt_q  <= cnt_q - CW'(1);
      done_q <= (cnt_q == CW'(1));
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done_o = done_q;
  assign root_o = root_q;

  AST_SQRT_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
    (cnt_q != '0 && !start_i) |=> (cnt_q == $past(cnt_q) - CW'(1))); // R5
  AST_SQRT_DONE: assert property (@(posedge clk_i) disable iff (rst_i)
    (cnt_q == CW'(1) && !start_i) |=> done_q); // R5
endmodule

// File: rtl/twg_rot.sv
// Complex product y = a * b in signed fixed point, rounded to nearest.
module twg_rot #(
  parameter int W    = 16,
  parameter int FRAC = 14
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic signed [W-1:0] ar_i,
  input  logic signed [W-1:0] ai_i,
  input  logic signed [W-1:0] br_i,
  input  logic signed [W-1:0] bi_i,
  output logic signed [W-1:0] yr_o,
  output logic signed [W-1:0] yi_o
);
  localparam int PW = 2 * W + 1;
  localparam logic signed [PW-1:0] RND = PW'(1 << (FRAC - 1));

  logic signed [2*W-1:0] p_rr, p_ii, p_ri, p_ir;
  logic signed [PW-1:0]  s_r, s_i, q_r, q_i;

  assign p_rr = ar_i * br_i;
  assign p_ii = ai_i * bi_i;
  assign p_ri = ar_i * bi_i;
  assign p_ir = ai_i * br_i;

  assign s_r = PW'(p_rr) - PW'(p_ii) + RND;
  assign s_i = PW'(p_ri) + PW'(p_ir) + RND;
  assign q_r = s_r >>> FRAC;
  assign q_i = s_i >>> FRAC;
  assign yr_o = W'(q_r);
  assign yi_o = W'(q_i);

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (rst_i)
    (q_r == PW'(yr_o)) && (q_i == PW'(yi_o))); // R4
endmodule

// File: rtl/twg_gen.sv
module twg_gen
  import twg_pkg::*;
#(
  parameter int W    = 16,
  parameter int FRAC = 14
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                row_init_i,
  input  logic                stage_init_i,
  input  logic                stage_end_i,
  input  logic                advance_i,
  input  logic                inverse_i,
  output logic signed [W-1:0] u1_o,
  output logic signed [W-1:0] u2_o,
  output logic                valid_o
);
  localparam int N    = FRAC + 1;
  localparam int RADW = 2 * N;
  localparam int SW   = W + 1;
  localparam int UCW  = $clog2(FRAC + 4);
  localparam logic signed [W-1:0] ONE_Q  = W'(1 << FRAC);
  localparam logic signed [W-1:0] MONE_Q = W'(-(1 << FRAC));

  logic signed [W-1:0] ca_q, sa_q, u1_q, u2_q, rot_r, rot_i;
  logic signed [W-1:0] root_c, root_s, sa_new;
  logic                valid_q, upd_q, pend_q, inv_q, sq_start, done_both;
  logic [UCW-1:0]      upd_cnt_q;
  logic signed [SW-1:0] half_arg [2];
  logic [RADW-1:0]     sq_rad  [2];
  logic [N-1:0]        sq_root [2];
  logic [1:0]          sq_done;
  twg_uop_e            uop;

  // Half-angle arguments: index 0 -> (1+c), index 1 -> (1-c); the /2 is
  // folded into the FRAC-1 shift that forms the radicand.
  assign half_arg[0] = SW'(ONE_Q) + SW'(ca_q);
  assign half_arg[1] = SW'(ONE_Q) - SW'(ca_q);
  assign sq_start    = stage_end_i && !upd_q && !row_init_i;

  for (genvar g = 0; g < 2; g++) begin : g_sqrt
    assign sq_rad[g] = RADW'($unsigned(half_arg[g])) << (FRAC - 1);
    twg_sqrt #(.N(N)) u_sqrt (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .start_i (sq_start),
      .rad_i   (sq_rad[g]),
      .done_o  (sq_done[g]),
      .root_o  (sq_root[g])
    );
  end

  assign done_both = &sq_done;
  assign root_c    = W'(sq_root[0]);
  assign root_s    = W'(sq_root[1]);
  assign sa_new    = inv_q ? root_s : -root_s;

  twg_rot #(.W(W), .FRAC(FRAC)) u_rot (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .ar_i  (u1_q),
    .ai_i  (u2_q),
    .br_i  (ca_q),
    .bi_i  (sa_q),
    .yr_o  (rot_r),
    .yi_o  (rot_i)
  );

  always_comb begin
    if (row_init_i)                          uop = UOP_ROW;
    else if (stage_init_i)                   uop = UOP_UNIT;
    else if (!upd_q && (advance_i || pend_q)) uop = UOP_TURN;
    else                                     uop = UOP_HOLD;
  end

  // Running twiddle
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      u1_q <= ONE_Q;
      u2_q <= '0;
    end else begin
      case (uop)
        UOP_ROW, UOP_UNIT: begin
          u1_q <= ONE_Q;
          u2_q <= '0;
        end
        UOP_TURN: begin
          u1_q <= rot_r;
          u2_q <= rot_i;
        end
        default: ;
      endcase
    end
  end

  // Base rotation and update control
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ca_q    <= MONE_Q;
      sa_q    <= '0;
      upd_q   <= 1'b0;
      inv_q   <= 1'b0;
      pend_q  <= 1'b0;
      valid_q <= 1'b1;
    end else if (row_init_i) begin
      ca_q    <= MONE_Q;
      sa_q    <= '0;
      upd_q   <= 1'b0;
      pend_q  <= 1'b0;
      valid_q <= 1'b1;
    end else if (upd_q) begin
      pend_q <= !stage_init_i && (pend_q || advance_i);
      if (done_both) begin
        ca_q    <= root_c;
        sa_q    <= sa_new;
        upd_q   <= 1'b0;
        valid_q <= stage_init_i || !(pend_q || advance_i);
      end
    end else begin
      pend_q <= 1'b0;
      if (stage_end_i) begin
        upd_q   <= 1'b1;
        inv_q   <= inverse_i;
        valid_q <= 1'b0;
      end else if (pend_q) begin
        valid_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i || !upd_q) upd_cnt_q <= '0;
    else                 upd_cnt_q <= upd_cnt_q + UCW'(1);
  end

  assign u1_o    = u1_q;
  assign u2_o    = u2_q;
  assign valid_o = valid_q;

  AST_ROW_START: assert property (@(posedge clk_i) disable iff (rst_i)
    row_init_i |=> (ca_q == MONE_Q && sa_q == '0 && u1_q == ONE_Q && u2_q == '0 && valid_q)); // R2
  AST_STAGE_UNIT: assert property (@(posedge clk_i) disable iff (rst_i)
    (stage_init_i && !row_init_i) |=> (u1_q == ONE_Q && u2_q == '0)); // R3
  AST_END_DROPS_VALID: assert property (@(posedge clk_i) disable iff (rst_i)
    (stage_end_i && !upd_q && !row_init_i) |=> !valid_q); // R5
  AST_UPD_BOUND: assert property (@(posedge clk_i) disable iff (rst_i)
    upd_cnt_q <= UCW'(FRAC + 2)); // R5
  AST_CA_NONNEG: assert property (@(posedge clk_i) disable iff (rst_i)
    (upd_q && done_both && !row_init_i) |=> (ca_q >= 0)); // R5
  AST_SA_FWD: assert property (@(posedge clk_i) disable iff (rst_i)
    (upd_q && done_both && !row_init_i && !inv_q) |=> (sa_q <= 0)); // R6
  AST_SA_INV: assert property (@(posedge clk_i) disable iff (rst_i)
    (upd_q && done_both && !row_init_i && inv_q) |=> (sa_q >= 0)); // R6
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    (upd_q && !row_init_i && !stage_init_i) |=> ($stable(u1_q) && $stable(u2_q))); // R7
endmodule

// File: tb/tb_twg_gen.sv
module tb_twg_gen;
  localparam int W    = 16;
  localparam int FRAC = 14;
  localparam int ONE  = 1 << FRAC;
  localparam real PI  = 3.14159265358979323846;
  localparam int NVEC = 6;
  // {inverse, stage ends before the stage, advances within the stage}
  localparam int VEC [NVEC][3] = '{
    '{0, 0, 2}, '{0, 1, 4}, '{1, 2, 4},
    '{0, 3, 8}, '{1, 3, 8}, '{0, 4, 16}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic row_init = 1'b0, stage_init = 1'b0, stage_end = 1'b0, advance = 1'b0, inverse = 1'b0;
  logic signed [W-1:0] u1, u2;
  logic valid;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  twg_gen #(.W(W), .FRAC(FRAC)) dut (
    .clk_i(clk), .rst_i(rst), .row_init_i(row_init), .stage_init_i(stage_init),
    .stage_end_i(stage_end), .advance_i(advance), .inverse_i(inverse),
    .u1_o(u1), .u2_o(u2), .valid_o(valid)
  );

  function automatic int qround(input real x);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  task automatic check(input string req, input int act, input int exp, input int tol);
    int d;
    n_chk++;
    d = (act > exp) ? act - exp : exp - act;
    if (d > tol) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (tol %0d)", req, act, exp, tol);
    end
  endtask

  task automatic pulse(input int sel);
    case (sel)
      0: row_init = 1'b1;
      1: stage_init = 1'b1;
      2: stage_end = 1'b1;
      default: advance = 1'b1;
    endcase
    @(negedge clk);
    row_init = 1'b0; stage_init = 1'b0; stage_end = 1'b0; advance = 1'b0;
  endtask

  task automatic wait_valid(output int cyc);
    cyc = 0;
    while (!valid && cyc < 64) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check("R1 u1", u1, ONE, 0);
    check("R1 u2", u2, 0, 0);
    check("R1 valid", valid, 1, 0);
    pulse(3);
    check("R1 base -1 u1", u1, -ONE, 0);
    check("R4 exact u2", u2, 0, 0);
    pulse(3);
    check("R4 full turn u1", u1, ONE, 0);

    // R5/R6: first stage end, forward, exact values
    inverse = 1'b0;
    pulse(2);
    check("R5 valid low", valid, 0, 0);
    wait_valid(cyc);
    check("R5 latency", cyc, FRAC + 2, 0);
    pulse(3);
    check("R6 fwd u1", u1, 0, 0);
    check("R6 fwd u2", u2, -ONE, 0);
    check("R4 valid stays", valid, 1, 0);

    // R3: stage init keeps the base
    pulse(1);
    check("R3 unit u1", u1, ONE, 0);
    check("R3 unit u2", u2, 0, 0);
    pulse(3);
    check("R3 base kept u2", u2, -ONE, 0);

    // R6: inverse direction
    pulse(0);
    inverse = 1'b1;
    pulse(2);
    wait_valid(cyc);
    pulse(3);
    check("R6 inv u1", u1, 0, 0);
    check("R6 inv u2", u2, ONE, 0);

    // R7: advance during the update is stalled, then uses the new base
    pulse(0);
    inverse = 1'b0;
    pulse(2);
    pulse(3);
    check("R7 valid low", valid, 0, 0);
    check("R7 hold u1", u1, ONE, 0);
    check("R7 hold u2", u2, 0, 0);
    wait_valid(cyc);
    check("R7 applied u1", u1, 0, 0);
    check("R7 applied u2", u2, -ONE, 0);
    check("R7 timing", cyc, FRAC + 2, 0);

    // R2: row start aborts an update in progress
    pulse(2);
    repeat (3) @(negedge clk);
    pulse(0);
    check("R2 valid", valid, 1, 0);
    check("R2 u1", u1, ONE, 0);
    repeat (20) @(negedge clk);
    check("R2 valid after", valid, 1, 0);
    pulse(3);
    check("R2 base -1 u1", u1, -ONE, 0);
    check("R2 base -1 u2", u2, 0, 0);

    // R8: table of stage/direction cases against cos/sin
    for (int v = 0; v < NVEC; v++) begin
      real th;
      inverse = VEC[v][0][0];
      pulse(0);
      for (int s = 0; s < VEC[v][1]; s++) begin
        pulse(2);
        wait_valid(cyc);
        check("R5 table latency", cyc, FRAC + 2, 0);
      end
      pulse(1);
      check("R3 table unit", u1, ONE, 0);
      th = PI / real'(1 << VEC[v][1]);
      if (VEC[v][0] == 0) th = -th;
      for (int j = 1; j <= VEC[v][2]; j++) begin
        pulse(3);
        check("R8 u1", u1, qround($cos(real'(j) * th) * real'(ONE)), 6 + 6 * j);
        check("R8 u2", u2, qround($sin(real'(j) * th) * real'(ONE)), 6 + 6 * j);
        check("R4 valid", valid, 1, 0);
      end
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule